// File: doc/BRIEF.md
# Indexed Block Register Target on SMBus

This block is an SMBus target that gives a host access to a nine-entry byte register file. Registers hold output-enable bits for nineteen clock outputs, show the configuration captured at power-up, mirror eight hardware enable pins and carry two identifier bytes. SCL and SDA are sampled with the system clock. The target drives SDA only through a drive-low output, because the line is open-drain. The system clock must run for the bus to work. Bus rates up to 100 kHz leave ample oversampling margin.

A write transaction carries a start index, a byte count and then the data bytes. Data bytes land at consecutive registers. A read transaction sets the start index and then issues a repeated START with the read address. The target answers first with the contents of its read-length register. It then returns that many registers in order. The 7-bit target address is one of nine values, selected by two three-level strap inputs. The straps are captured once, on the first rising edge of power-good, together with the frequency-select and PLL-mode inputs.

Top module: `smbidx_target`

## Requirements
- R1: The address uses level codes 00 = low, 01 = mid, and 10 or 11 = high. The major strap times three plus the minor strap selects the 8-bit write address from D8, DA, DE, C2, C4, C6, CA, CC, CE (hex). The 7-bit address is that value shifted right by one. The read address is the same 7 bits with R/W = 1.
- R2: Straps, PLL mode and frequency select are captured on the first rising edge of power-good only. Later edges and later input changes have no effect. Before the capture, the target acknowledges nothing.
- R3: A write is START, write address, index N, count X, then data. The target ACKs each of these bytes. Data byte k lands in register N+k.
- R4: Once X data bytes have been written, any further data byte gets a NACK and changes no register.
- R5: A read returns the read-length value L first. It then returns registers N to N+L-1 in order. Any byte clocked out after those is 0xFF, meaning the line is released.
- R6: Register 0 layout: bits 7:6 are the captured PLL mode, bits 5:3 are writable enables for outputs 18:16, bits 2:1 read 0, and bit 0 is the captured frequency select. Writes reach only bits 5:3.
- R7: Registers 1 and 2 are writable enables for outputs 7:0 and 15:8, with bit i controlling output 8·(reg−1)+i. All nineteen enables reset to 1.
- R8: Register 3 reads the live value of the eight enable pins. Bit 7 is the pin for output 12 and bit 0 is the pin for output 5.
- R9: Registers 4 and 8 read 0. Register 5 reads the revision/vendor parameter and register 6 reads the device parameter. Writes to registers 3, 4, 5, 6 and 8 have no effect.
- R10: Register 7 bits 4:0 hold the read length, which resets to 8. Bits 7:5 read 0.
- R11: The register index saturates at 8. This applies to an index byte above 8 and to auto-increment past 8.
- R12: An address byte that does not match gets a NACK. The target then ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_low_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| pwr_good_i | input | 1 | Power-good; first rising edge captures straps |
| strap_major_i | input | 2 | Major address strap level code |
| strap_minor_i | input | 2 | Minor address strap level code |
| pll_mode_i | input | 2 | PLL mode code captured at power-good |
| freq_sel_i | input | 1 | Frequency select captured at power-good |
| oe_pin_i | input | 8 | Live enable pins for outputs 12:5 |
| out_en_o | output | 19 | Output enables for outputs 18:0 |

## Verification
The bench drives strap values that differ from the power-up ones after capture, and pulses power-good a second time. A design that re-sampled on either event would move its address or change register 0. It sends more data bytes than the announced count, writes to read-only, reserved and out-of-range indices, and reads past the end of the register file. A wrong design would corrupt enables, fail to saturate the index, or return non-zero filler. It also reprograms the read length and reads beyond it. A target that ignored the length register, or kept driving after the length ran out, would return bytes other than 0xFF at the tail.

// File: rtl/smbidx_pkg.sv
package smbidx_pkg;
   localparam int unsigned REG_COUNT = 9;
   localparam int unsigned IDX_W     = 4;
   localparam int unsigned LAST_IDX  = REG_COUNT - 1;
   localparam int unsigned EN_W      = 19;

   typedef enum logic [2:0] {
      PH_IDLE, PH_ADDR, PH_INDEX, PH_WCNT, PH_WDATA, PH_RCNT, PH_RDATA
   } phase_t;

   // low = 0, mid = 1, anything above = high
   function automatic logic [1:0] level_rank(input logic [1:0] code);
      return (code == 2'b00) ? 2'd0 : (code == 2'b01) ? 2'd1 : 2'd2;
   endfunction

   function automatic logic [6:0] strap_addr(input logic [1:0] major, input logic [1:0] minor);
      logic [3:0] sel;
      logic [7:0] a8;
      sel = 4'(level_rank(major)) * 4'd3 + 4'(level_rank(minor));
      case (sel)
         4'd0:    a8 = 8'hD8;
         4'd1:    a8 = 8'hDA;
         4'd2:    a8 = 8'hDE;
         4'd3:    a8 = 8'hC2;
         4'd4:    a8 = 8'hC4;
         4'd5:    a8 = 8'hC6;
         4'd6:    a8 = 8'hCA;
         4'd7:    a8 = 8'hCC;
         default: a8 = 8'hCE;
      endcase
      return a8[7:1];
   endfunction
endpackage

// File: rtl/smbidx_line_sync.sv
module smbidx_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbidx_strap_latch.sv
module smbidx_strap_latch (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_good_i,
   input  logic [1:0] strap_major_i,
   input  logic [1:0] strap_minor_i,
   input  logic [1:0] pll_mode_i,
   input  logic       freq_sel_i,
   output logic       cfg_valid_o,
   output logic [6:0] addr_o,
   output logic [1:0] pll_mode_o,
   output logic       freq_sel_o
);
   import smbidx_pkg::*;

   logic [1:0] pg_sync;
   logic       pg_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_sync     <= '0;
         pg_d        <= 1'b0;
         cfg_valid_o <= 1'b0;
         addr_o      <= '0;
         pll_mode_o  <= '0;
         freq_sel_o  <= 1'b0;
      end else begin
         pg_sync <= {pg_sync[0], pwr_good_i};
         pg_d    <= pg_sync[1];
         if (pg_sync[1] && !pg_d && !cfg_valid_o) begin
            cfg_valid_o <= 1'b1;
            addr_o      <= strap_addr(strap_major_i, strap_minor_i);
            pll_mode_o  <= pll_mode_i;
            freq_sel_o  <= freq_sel_i;
         end
      end
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid_o && $past(cfg_valid_o) |-> $stable(addr_o) && $stable(pll_mode_o) && $stable(freq_sel_o)); // R2
endmodule

// File: rtl/smbidx_regs.sv
module smbidx_regs #(
   parameter logic [7:0]  REV_ID  = 8'h31,
   parameter logic [7:0]  DEV_ID  = 8'hC9,
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned CNT_RST = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [smbidx_pkg::IDX_W-1:0]       wr_idx,
   input  logic [7:0]                         wr_data,
   input  logic [smbidx_pkg::IDX_W-1:0]       rd_idx,
   input  logic [1:0]                         pll_mode,
   input  logic                               freq_sel,
   input  logic [7:0]                         oe_pin,
   output logic [7:0]                         rd_data,
   output logic [smbidx_pkg::EN_W-1:0]        out_en,
   output logic [CNT_W-1:0]                   rd_len
);
   import smbidx_pkg::*;

   logic [2:0] en_top;

   // two full-byte enable banks, registers 1 and 2
   for (genvar g = 0; g < 2; g++) begin : g_bank
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= 8'hFF;
         else if (wr_en && wr_idx == IDX_W'(g + 1))
            q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_top <= 3'b111;
         rd_len <= CNT_W'(CNT_RST);
      end else if (wr_en) begin
         if (wr_idx == IDX_W'(0)) en_top <= wr_data[5:3];
         if (wr_idx == IDX_W'(7)) rd_len <= wr_data[CNT_W-1:0];
      end
   end

   always_comb begin
      case (rd_idx)
         IDX_W'(0): rd_data = {pll_mode, en_top, 2'b00, freq_sel};
         IDX_W'(1): rd_data = g_bank[0].q;
         IDX_W'(2): rd_data = g_bank[1].q;
         IDX_W'(3): rd_data = oe_pin;
         IDX_W'(5): rd_data = REV_ID;
         IDX_W'(6): rd_data = DEV_ID;
         IDX_W'(7): rd_data = 8'(rd_len);
         default:   rd_data = 8'h00;
      endcase
   end

   assign out_en = {en_top, g_bank[1].q, g_bank[0].q};

   AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !(wr_idx inside {IDX_W'(0), IDX_W'(1), IDX_W'(2), IDX_W'(7)})
      |=> $stable(out_en) && $stable(rd_len)); // R9
endmodule

// File: rtl/smbidx_target.sv
module smbidx_target #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  REV_ID      = 8'h31,
   parameter logic [7:0]  DEV_ID      = 8'hC9,
   parameter int unsigned CNT_W       = 5,
   parameter int unsigned CNT_RST     = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   output logic        sda_low_o,
   input  logic        pwr_good_i,
   input  logic [1:0]  strap_major_i,
   input  logic [1:0]  strap_minor_i,
   input  logic [1:0]  pll_mode_i,
   input  logic        freq_sel_i,
   input  logic [7:0]  oe_pin_i,
   output logic [18:0] out_en_o
);
   import smbidx_pkg::*;

   localparam logic [IDX_W-1:0] LAST_I = IDX_W'(LAST_IDX);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CNT_W > 8 || CNT_RST >= (1 << CNT_W)) begin : g_bad_cnt
      $error("read length field does not fit");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic cfg_valid, freq_q;
   logic [6:0] my_addr;
   logic [1:0] pll_q;
   logic [7:0] rd_data, tx_byte;
   logic [CNT_W-1:0] rd_len;

   phase_t          phase;
   logic [3:0]      bit_cnt;
   logic [7:0]      shreg, budget;
   logic            ack_slot, tx_mode, host_ack, sda_low_q;
   logic [IDX_W-1:0] idx, next_idx, idx_from_byte;
   logic            byte_done, byte_ok, wr_en;

   smbidx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   smbidx_strap_latch u_strap (
      .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good_i),
      .strap_major_i(strap_major_i), .strap_minor_i(strap_minor_i),
      .pll_mode_i(pll_mode_i), .freq_sel_i(freq_sel_i),
      .cfg_valid_o(cfg_valid), .addr_o(my_addr),
      .pll_mode_o(pll_q), .freq_sel_o(freq_q));

   smbidx_regs #(.REV_ID(REV_ID), .DEV_ID(DEV_ID), .CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx), .wr_data(shreg),
      .rd_idx(idx), .pll_mode(pll_q), .freq_sel(freq_q), .oe_pin(oe_pin_i),
      .rd_data(rd_data), .out_en(out_en_o), .rd_len(rd_len));

   assign next_idx      = (idx >= LAST_I) ? LAST_I : idx + IDX_W'(1);
   assign idx_from_byte = (shreg > 8'(LAST_IDX)) ? LAST_I : shreg[IDX_W-1:0];
   assign byte_done     = (phase != PH_IDLE) && !start_det && !stop_det && !tx_mode &&
                          !ack_slot && scl_fall && (bit_cnt == 4'd8);
   assign wr_en         = byte_done && (phase == PH_WDATA) && (budget != 8'd0);

   always_comb begin
      case (phase)
         PH_ADDR:            byte_ok = cfg_valid && (shreg[7:1] == my_addr);
         PH_INDEX, PH_WCNT:  byte_ok = 1'b1;
         PH_WDATA:           byte_ok = (budget != 8'd0);
         default:            byte_ok = 1'b0;
      endcase
      if (phase == PH_RCNT)       tx_byte = 8'(rd_len);
      else if (budget != 8'd0)    tx_byte = rd_data;
      else                        tx_byte = 8'hFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE; bit_cnt <= '0; shreg <= '0; budget <= '0;
         ack_slot <= 1'b0; tx_mode <= 1'b0; host_ack <= 1'b0; sda_low_q <= 1'b0; idx <= '0;
      end else if (stop_det) begin
         phase <= PH_IDLE; ack_slot <= 1'b0; tx_mode <= 1'b0; sda_low_q <= 1'b0;
      end else if (start_det) begin
         phase <= PH_ADDR; bit_cnt <= '0; ack_slot <= 1'b0; tx_mode <= 1'b0; sda_low_q <= 1'b0;
      end else if (phase != PH_IDLE) begin
         if (!tx_mode && !ack_slot) begin
            if (scl_rise) begin
               shreg   <= {shreg[6:0], sda_s};
               bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
               ack_slot  <= 1'b1;
               sda_low_q <= byte_ok;
               case (phase)
                  PH_ADDR:  if (byte_ok) phase <= shreg[0] ? PH_RCNT : PH_INDEX;
                  PH_INDEX: begin idx <= idx_from_byte; phase <= PH_WCNT; end
                  PH_WCNT:  begin budget <= shreg; phase <= PH_WDATA; end
                  PH_WDATA: if (byte_ok) begin budget <= budget - 8'd1; idx <= next_idx; end
                  default: ;
               endcase
            end
         end else if (!tx_mode) begin
            if (scl_fall) begin
               ack_slot <= 1'b0;
               bit_cnt  <= '0;
               if (!sda_low_q) begin
                  phase <= PH_IDLE;
               end else if (phase == PH_RCNT) begin
                  tx_mode   <= 1'b1;
                  shreg     <= tx_byte;
                  sda_low_q <= ~tx_byte[7];
                  budget    <= 8'(rd_len);
                  phase     <= PH_RDATA;
               end else begin
                  sda_low_q <= 1'b0;
               end
            end
         end else if (!ack_slot) begin
            if (scl_fall) begin
               if (bit_cnt == 4'd7) begin
                  sda_low_q <= 1'b0;
                  ack_slot  <= 1'b1;
               end else begin
                  bit_cnt   <= bit_cnt + 4'd1;
                  shreg     <= {shreg[6:0], 1'b0};
                  sda_low_q <= ~shreg[6];
               end
            end
         end else begin
            if (scl_rise) begin
               host_ack <= ~sda_s;
            end else if (scl_fall) begin
               ack_slot <= 1'b0;
               bit_cnt  <= '0;
               if (host_ack) begin
                  shreg     <= tx_byte;
                  sda_low_q <= ~tx_byte[7];
                  if (budget != 8'd0) begin
                     budget <= budget - 8'd1;
                     idx    <= next_idx;
                  end
               end else begin
                  phase   <= PH_IDLE;
                  tx_mode <= 1'b0;
               end
            end
         end
      end
   end

   assign sda_low_o = sda_low_q;

   AST_SILENT_UNCONFIGURED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_valid |-> !sda_low_q); // R2
   AST_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_low_q) |-> !scl_s); // R3
   AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> sda_low_q); // R4
   AST_IDX_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST_I); // R11
endmodule

// File: tb/smbidx_target_tb.sv
module smbidx_target_tb;
   localparam int Q = 12;
   localparam logic [7:0] REV = 8'h31;
   localparam logic [7:0] DEV = 8'hC9;
   localparam logic [6:0] MY_ADDR = 7'h63;   // C6 >> 1: major mid, minor high

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic host_scl = 1'b1, host_sda = 1'b1;
   logic sda_low, sda_bus;
   logic pwr_good = 1'b0;
   logic [1:0] s_maj = 2'b00, s_min = 2'b00, pll = 2'b00;
   logic fs = 1'b0;
   logic [7:0] oe_pins = 8'h00;
   logic [18:0] out_en;

   assign sda_bus = host_sda & ~sda_low;

   smbidx_target #(.REV_ID(REV), .DEV_ID(DEV)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus), .sda_low_o(sda_low),
      .pwr_good_i(pwr_good), .strap_major_i(s_maj), .strap_minor_i(s_min),
      .pll_mode_i(pll), .freq_sel_i(fs), .oe_pin_i(oe_pins), .out_en_o(out_en));

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0, cmp_en = 1'b0;

   // behavioural register model
   logic [2:0] m_hi = 3'b111;
   logic [7:0] m_b1 = 8'hFF, m_b2 = 8'hFF;
   logic [4:0] m_cnt = 5'd8;
   logic [1:0] m_pll = 2'b00;
   logic       m_fs = 1'b0;
   int         m_idx = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int sat(input int i);
      return (i > 8) ? 8 : i;
   endfunction

   function automatic logic [7:0] mdl_rd(input int i);
      case (i)
         0: return {m_pll, m_hi, 2'b00, m_fs};
         1: return m_b1;
         2: return m_b2;
         3: return oe_pins;
         5: return REV;
         6: return DEV;
         7: return {3'b000, m_cnt};
         default: return 8'h00;
      endcase
   endfunction

   task automatic mdl_wr(input int i, input logic [7:0] d);
      case (i)
         0: m_hi = d[5:3];
         1: m_b1 = d;
         2: m_b2 = d;
         7: m_cnt = d[4:0];
         default: ;
      endcase
   endtask

   // per-clock comparison of the enables against the model (R7)
   always @(negedge clk)
      if (cmp_en) chk("R7 per-cycle enables", 32'(out_en), 32'({m_hi, m_b2, m_b1}));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      host_sda = 1'b1; tick(Q);
      host_scl = 1'b1; tick(Q);
      host_sda = 1'b0; tick(Q);
      host_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      host_sda = 1'b0; tick(Q);
      host_scl = 1'b1; tick(Q);
      host_sda = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         host_sda = b[i]; tick(Q);
         host_scl = 1'b1; tick(2 * Q);
         if (i == 0) cmp_en = 1'b0;
         host_scl = 1'b0; tick(Q);
      end
      host_sda = 1'b1; tick(Q);
      host_scl = 1'b1; tick(Q);
      acked = !sda_bus;
      tick(Q);
      host_scl = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input bit ack, output logic [7:0] b);
      host_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         host_scl = 1'b1; tick(Q);
         b[i] = sda_bus;
         tick(Q);
         host_scl = 1'b0; tick(Q);
      end
      host_sda = ack ? 1'b0 : 1'b1; tick(Q);
      host_scl = 1'b1; tick(2 * Q);
      host_scl = 1'b0; tick(Q);
      host_sda = 1'b1;
   endtask

   task automatic addr_probe(input logic [6:0] a, input bit exp, input string req);
      bit ak;
      bus_start();
      send_byte({a, 1'b0}, ak);
      chk(req, 32'(ak), 32'(exp));
      if (!exp) begin
         send_byte(8'h00, ak);
         chk("R12 bus ignored after refusal", 32'(ak), 0);
      end
      cmp_en = 1'b1;
      bus_stop();
   endtask

   task automatic wr_txn(input logic [7:0] n, input logic [7:0] x, input logic [31:0] data, input int nbytes);
      bit ak;
      int rem;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ak); chk("R3 write address ack", 32'(ak), 1); cmp_en = 1'b1;
      send_byte(n, ak); chk("R3 index ack", 32'(ak), 1); m_idx = sat(int'(n)); cmp_en = 1'b1;
      send_byte(x, ak); chk("R3 count ack", 32'(ak), 1); rem = int'(x); cmp_en = 1'b1;
      for (int k = 0; k < nbytes; k++) begin
         send_byte(data[8*k +: 8], ak);
         if (rem > 0) begin
            chk("R3 data byte ack", 32'(ak), 1);
            mdl_wr(m_idx, data[8*k +: 8]);
            m_idx = sat(m_idx + 1);
            rem--;
            cmp_en = 1'b1;
         end else begin
            chk("R4 byte past count refused", 32'(ak), 0);
            cmp_en = 1'b1;
            break;
         end
      end
      bus_stop();
   endtask

   task automatic rd_txn(input logic [7:0] n, input int nread, input string req);
      bit ak;
      int rem;
      logic [7:0] b;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ak); chk("R5 write address ack", 32'(ak), 1); cmp_en = 1'b1;
      send_byte(n, ak); chk("R5 index ack", 32'(ak), 1); m_idx = sat(int'(n)); cmp_en = 1'b1;
      bus_start();
      send_byte({MY_ADDR, 1'b1}, ak); chk("R1 read address ack", 32'(ak), 1); cmp_en = 1'b1;
      recv_byte(nread != 0, b);
      chk("R10 leading length byte", 32'(b), 32'(m_cnt));
      rem = int'(m_cnt);
      for (int k = 0; k < nread; k++) begin
         recv_byte(k != nread - 1, b);
         if (rem > 0) begin
            chk(req, 32'(b), 32'(mdl_rd(m_idx)));
            m_idx = sat(m_idx + 1);
            rem--;
         end else begin
            chk("R5 filler after length", 32'(b), 32'h0FF);
         end
      end
      bus_stop();
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(3);
      chk("R7 reset enables all ones", 32'(out_en), 32'h7FFFF);
      chk("R2 line released after reset", 32'(sda_low), 0);
      cmp_en = 1'b1;

      addr_probe(MY_ADDR, 1'b0, "R2 no reply before power good");

      s_maj = 2'b01; s_min = 2'b10; pll = 2'b10; fs = 1'b1;
      m_pll = 2'b10; m_fs = 1'b1;
      tick(2);
      pwr_good = 1'b1;
      tick(8);
      s_maj = 2'b00; s_min = 2'b00; pll = 2'b01; fs = 1'b0;

      addr_probe(MY_ADDR, 1'b1, "R1 strap address answers");
      addr_probe(7'h6C, 1'b0, "R12 foreign address refused");

      pwr_good = 1'b0; tick(6); pwr_good = 1'b1; tick(8);
      addr_probe(MY_ADDR, 1'b1, "R2 address kept after second power good");

      rd_txn(8'd0, 8, "R2 R6 default block read");

      wr_txn(8'd1, 8'd2, 32'h0000_3C5A, 2);
      chk("R7 enables after bank write", 32'(out_en), 32'({3'b111, 8'h3C, 8'h5A}));

      wr_txn(8'd0, 8'd1, 32'h0000_0000, 1);
      rd_txn(8'd0, 1, "R6 register 0 after clearing enables");
      wr_txn(8'd0, 8'd1, 32'h0000_00E9, 1);
      rd_txn(8'd0, 1, "R6 only bits 5:3 written");

      wr_txn(8'd3, 8'd4, 32'hDEAD_BEEF, 4);
      rd_txn(8'd3, 8, "R9 R11 read-only and saturated read");

      wr_txn(8'd7, 8'd1, 32'h0000_00E3, 1);
      rd_txn(8'd7, 5, "R10 R11 length register and tail");

      wr_txn(8'd1, 8'd1, 32'h0000_1177, 2);
      chk("R4 second bank untouched", 32'(out_en[15:8]), 32'h3C);

      wr_txn(8'h20, 8'd1, 32'h0000_0000, 1);
      chk("R11 out-of-range write inert", 32'(out_en), 32'({m_hi, m_b2, m_b1}));

      oe_pins = 8'hA4;
      rd_txn(8'd3, 1, "R8 live enable pins");
      oe_pins = 8'h5B;
      rd_txn(8'd3, 2, "R8 live pins after change");

      tick(4);
      cmp_en = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung run, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule